// File: doc/BRIEF.md
# Shadow Stack Page Access Checker

This block sits beside a simplified memory access path and judges each access against the page attribute bits that travel with the request. From the present, writable and dirty bits it works out whether the target page belongs to a shadow stack. It then checks whether the kind of access is legal on that page at the current privilege level. The result is either a pass or a fault with a code that says why the access was refused.

Requests are marked by a one-cycle valid strobe. The verdict, an allow flag and a fault code, is registered and appears on the cycle after the strobe. When no request is present, both outputs read zero. A page is a shadow-stack page only when it is present, its writable bit is clear and its dirty bit is set. Ordinary data traffic is kept off such pages. Traffic that a call or a return generates on the shadow stack is kept off every other page.

Access kind encoding on `acc_kind`: 0 ordinary store, 1 ordinary push/pop, 2 shadow push from a call, 3 shadow pop from a return, 4 explicit shadow write, 5 to 7 undefined. Fault code encoding on `chk_fault`: 0 none, 1 page not present, 2 ordinary access to a shadow page, 3 explicit shadow write above privilege 0, 4 shadow access to a non-shadow page, 5 ordinary write to a read-only page, 6 undefined access kind.

Top module: `shadow_access_check`

## Requirements
- R1: A page is classed as shadow stack exactly when `pg_present`=1, `pg_writable`=0 and `pg_dirty`=1. Every other attribute combination is ordinary memory.
- R2: When `pg_present`=0, the verdict is fault code 1 with allow 0, whatever the kind and privilege. This check outranks every other check.
- R3: An ordinary store (kind 0) to a shadow-stack page gives fault code 2.
- R4: An ordinary push/pop (kind 1) to a shadow-stack page gives fault code 2.
- R5: A shadow push (kind 2) or a shadow pop (kind 3) to a shadow-stack page is allowed at any privilege level.
- R6: A shadow push or pop to a present page that is not a shadow-stack page gives fault code 4.
- R7: An explicit shadow write (kind 4) at a privilege level other than 0 gives fault code 3, whatever the page class. At privilege 0 it is allowed on a shadow-stack page and gives code 4 on any other present page.
- R8: An ordinary store or push/pop to a present non-shadow page is allowed when `pg_writable`=1 and gives fault code 5 when `pg_writable`=0.
- R9: Access kinds 5 to 7 on a present page give fault code 6.
- R10: The verdict for a strobe sampled at a rising edge appears on the outputs right after that edge. An edge with `acc_valid`=0, or with `rst_n`=0 (synchronous active-low reset), leaves allow 0 and fault code 0.
- R11: After a valid request, `chk_allow` is 1 exactly when `chk_fault` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Request strobe |
| acc_kind | input | 3 | Access kind (encoding above) |
| acc_priv | input | 2 | Current privilege level, 0 most privileged |
| pg_present | input | 1 | Page present bit |
| pg_writable | input | 1 | Page writable bit |
| pg_dirty | input | 1 | Page dirty bit |
| chk_allow | output | 1 | Registered pass verdict |
| chk_fault | output | 3 | Registered fault code (encoding above) |

## Verification
Every verdict is due exactly one rising edge after its request. The bench drives the request on a falling edge, lets one rising edge register it, and reads `chk_allow` and `chk_fault` on the next falling edge. After each request it drops the strobe for one edge and checks that both outputs return to zero, so a stale verdict cannot hide a missing one. Reset is checked the same way: the outputs are read one falling edge after a reset edge that followed a valid, allowed request.

// File: rtl/sspc_pkg.sv
// Shared encodings for the shadow stack page access checker.
// Assumes a 3-bit access kind field and a 3-bit fault code field.
package sspc_pkg;

    localparam int KIND_W  = 3;
    localparam int FAULT_W = 3;

    typedef enum logic [KIND_W-1:0] {
        KIND_STORE    = 3'd0,
        KIND_PUSHPOP  = 3'd1,
        KIND_SH_CALL  = 3'd2,
        KIND_SH_RET   = 3'd3,
        KIND_SH_WRITE = 3'd4
    } acc_kind_e;

    typedef enum logic [FAULT_W-1:0] {
        FLT_NONE      = 3'd0,
        FLT_ABSENT    = 3'd1,
        FLT_ON_SHADOW = 3'd2,
        FLT_PRIV      = 3'd3,
        FLT_OFF_SHAD  = 3'd4,
        FLT_READONLY  = 3'd5,
        FLT_BAD_KIND  = 3'd6
    } fault_e;

    typedef struct packed {
        logic present;
        logic writable;
        logic shadow;
    } page_class_t;

endpackage

// File: rtl/sspc_page_classify.sv
// Page classifier: turns raw attribute bits into a page class.
// A page is shadow stack only when present, read-only and dirty.
// Assumes the attribute bits are stable for the cycle they are sampled.
module sspc_page_classify
    import sspc_pkg::*;
(
    input  logic        present_i,
    input  logic        writable_i,
    input  logic        dirty_i,
    output page_class_t class_o
);

    // Combine the attribute bits into the class record.
    always_comb begin
        class_o.present  = present_i;
        class_o.writable = writable_i;
        class_o.shadow   = present_i & ~writable_i & dirty_i;
    end

endmodule

// File: rtl/sspc_rule_eval.sv
// Rule evaluator: decides the verdict for one access from its kind,
// privilege and page class. The priority order is: not-present, then
// undefined kind, then the rule for that kind.
// Assumes privilege level SUPER_LVL is the only level allowed to use
// the explicit shadow write.
module sspc_rule_eval
    import sspc_pkg::*;
#(
    parameter int PRIV_W    = 2,
    parameter int SUPER_LVL = 0
) (
    input  logic [KIND_W-1:0] kind_i,
    input  logic [PRIV_W-1:0] priv_i,
    input  page_class_t       class_i,
    output logic              allow_o,
    output fault_e            fault_o
);

    localparam logic [PRIV_W-1:0] SUPER = PRIV_W'(SUPER_LVL);

    fault_e code;

    // Pick the fault code by priority, then the kind-specific rule.
    always_comb begin
        code = FLT_NONE;
        if (!class_i.present) begin
            code = FLT_ABSENT;
        end else begin
            case (kind_i)
                KIND_STORE, KIND_PUSHPOP: begin
                    if (class_i.shadow)         code = FLT_ON_SHADOW;
                    else if (!class_i.writable) code = FLT_READONLY;
                end
                KIND_SH_CALL, KIND_SH_RET: begin
                    if (!class_i.shadow) code = FLT_OFF_SHAD;
                end
                KIND_SH_WRITE: begin
                    if (priv_i != SUPER)     code = FLT_PRIV;
                    else if (!class_i.shadow) code = FLT_OFF_SHAD;
                end
                default: code = FLT_BAD_KIND;
            endcase
        end
    end

    // The access passes only when no rule raised a fault.
    always_comb begin
        fault_o = code;
        allow_o = (code == FLT_NONE);
    end

endmodule

// File: rtl/sspc_out_reg.sv
// Output register: captures the verdict on a valid strobe and clears
// it on idle cycles and on synchronous active-low reset.
// Assumes the verdict inputs are settled before the rising edge.
module sspc_out_reg
    import sspc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   valid_i,
    input  logic   allow_i,
    input  fault_e fault_i,
    output logic   allow_q,
    output fault_e fault_q
);

    // Register the verdict; idle and reset edges leave a clear result.
    always_ff @(posedge clk) begin
        if (!rst_n || !valid_i) begin
            allow_q <= 1'b0;
            fault_q <= FLT_NONE;
        end else begin
            allow_q <= allow_i;
            fault_q <= fault_i;
        end
    end

    // R10: an idle edge leaves both outputs clear.
    p_idle_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!allow_q && fault_q == FLT_NONE));

    // R11: the output pair never shows allow with a fault code.
    p_allow_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (allow_q == (fault_q == FLT_NONE)));

endmodule

// File: rtl/shadow_access_check.sv
// Top level: classifies the page of each access, applies the access
// rules and registers the verdict one cycle after the strobe.
// Assumes one request per valid cycle, with no back-pressure.
module shadow_access_check
    import sspc_pkg::*;
#(
    parameter int PRIV_W    = 2,
    parameter int SUPER_LVL = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic [KIND_W-1:0]   acc_kind,
    input  logic [PRIV_W-1:0]   acc_priv,
    input  logic                pg_present,
    input  logic                pg_writable,
    input  logic                pg_dirty,
    output logic                chk_allow,
    output logic [FAULT_W-1:0]  chk_fault
);

    page_class_t pg_class;
    logic        nxt_allow;
    fault_e      nxt_fault;
    fault_e      q_fault;

    sspc_page_classify u_class (
        .present_i  (pg_present),
        .writable_i (pg_writable),
        .dirty_i    (pg_dirty),
        .class_o    (pg_class)
    );

    sspc_rule_eval #(
        .PRIV_W    (PRIV_W),
        .SUPER_LVL (SUPER_LVL)
    ) u_rule (
        .kind_i  (acc_kind),
        .priv_i  (acc_priv),
        .class_i (pg_class),
        .allow_o (nxt_allow),
        .fault_o (nxt_fault)
    );

    sspc_out_reg u_oreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (acc_valid),
        .allow_i (nxt_allow),
        .fault_i (nxt_fault),
        .allow_q (chk_allow),
        .fault_q (q_fault)
    );

    // Present the registered fault code as a plain vector.
    always_comb chk_fault = q_fault;

    // R2: a missing page reports the not-present code on the next cycle.
    p_absent_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !pg_present) |=> (!chk_allow && chk_fault == FLT_ABSENT));

    // R3 and R4: ordinary traffic onto a read-only dirty page is refused.
    p_plain_on_shadow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && pg_present && !pg_writable && pg_dirty &&
         (acc_kind == KIND_STORE || acc_kind == KIND_PUSHPOP))
        |=> (!chk_allow && chk_fault == FLT_ON_SHADOW));

    // R5: call/return shadow traffic onto a shadow page passes.
    p_shadow_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && pg_present && !pg_writable && pg_dirty &&
         (acc_kind == KIND_SH_CALL || acc_kind == KIND_SH_RET))
        |=> chk_allow);

    // R7: explicit shadow writes above the privileged level are refused.
    p_priv_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && pg_present && acc_kind == KIND_SH_WRITE &&
         acc_priv != PRIV_W'(SUPER_LVL))
        |=> (!chk_allow && chk_fault == FLT_PRIV));

    // R6: shadow traffic onto a writable page is refused.
    p_shadow_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && pg_present && pg_writable &&
         (acc_kind == KIND_SH_CALL || acc_kind == KIND_SH_RET))
        |=> (chk_fault == FLT_OFF_SHAD));

endmodule

// File: tb/sim_shadow_access_check.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_shadow_access_check;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_valid = 1'b0;
    logic [2:0] acc_kind = 3'd0;
    logic [1:0] acc_priv = 2'd0;
    logic       pg_present = 1'b0;
    logic       pg_writable = 1'b0;
    logic       pg_dirty = 1'b0;
    logic       chk_allow;
    logic [2:0] chk_fault;

    int n_checks = 0;
    int n_errors = 0;

    shadow_access_check u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_kind    (acc_kind),
        .acc_priv    (acc_priv),
        .pg_present  (pg_present),
        .pg_writable (pg_writable),
        .pg_dirty    (pg_dirty),
        .chk_allow   (chk_allow),
        .chk_fault   (chk_fault)
    );

    always #5 clk = ~clk;

    task automatic expect_out(input string req, input logic ea, input logic [2:0] ef);
        n_checks++;
        if (chk_allow !== ea || chk_fault !== ef) begin
            n_errors++;
            $display("FAIL %s: allow=%0b fault=%0d expected allow=%0b fault=%0d",
                     req, chk_allow, chk_fault, ea, ef);
        end
    endtask

    // Drive one request at a falling edge, check it one edge later,
    // then an idle edge that must clear the outputs (R10).
    task automatic access(input string req, input logic [2:0] k, input logic [1:0] pv,
                          input logic p, input logic w, input logic d,
                          input logic [2:0] ef);
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = k; acc_priv = pv;
        pg_present = p; pg_writable = w; pg_dirty = d;
        @(negedge clk);
        acc_valid = 1'b0;
        expect_out(req, ef == 3'd0, ef);
        @(negedge clk);
        expect_out("R10 idle", 1'b0, 3'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        expect_out("R10 reset", 1'b0, 3'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_classify();
        // R1: only present/read-only/dirty is shadow; a call push shows it.
        access("R1 p1w0d1", 3'd2, 2'd3, 1, 0, 1, 3'd0);
        access("R1 p1w0d0", 3'd2, 2'd3, 1, 0, 0, 3'd4);
        access("R1 p1w1d1", 3'd2, 2'd3, 1, 1, 1, 3'd4);
        access("R1 p1w1d0", 3'd2, 2'd3, 1, 1, 0, 3'd4);
    endtask

    task automatic t_absent();
        access("R2 store", 3'd0, 2'd0, 0, 1, 0, 3'd1);
        access("R2 shwrite priv3", 3'd4, 2'd3, 0, 0, 1, 3'd1);
        access("R2 badkind", 3'd7, 2'd0, 0, 0, 1, 3'd1);
    endtask

    task automatic t_plain_on_shadow();
        access("R3 store", 3'd0, 2'd0, 1, 0, 1, 3'd2);
        access("R4 pushpop", 3'd1, 2'd3, 1, 0, 1, 3'd2);
    endtask

    task automatic t_shadow_traffic();
        access("R5 ret priv0", 3'd3, 2'd0, 1, 0, 1, 3'd0);
        access("R5 call priv2", 3'd2, 2'd2, 1, 0, 1, 3'd0);
        access("R6 ret rw page", 3'd3, 2'd0, 1, 1, 0, 3'd4);
        access("R6 call ro clean", 3'd2, 2'd0, 1, 0, 0, 3'd4);
    endtask

    task automatic t_priv_write();
        access("R7 priv0 shadow", 3'd4, 2'd0, 1, 0, 1, 3'd0);
        access("R7 priv1 shadow", 3'd4, 2'd1, 1, 0, 1, 3'd3);
        access("R7 priv3 plain", 3'd4, 2'd3, 1, 1, 0, 3'd3);
        access("R7 priv0 plain", 3'd4, 2'd0, 1, 1, 1, 3'd4);
    endtask

    task automatic t_plain_pages();
        access("R8 store rw", 3'd0, 2'd3, 1, 1, 0, 3'd0);
        access("R8 pushpop rw dirty", 3'd1, 2'd0, 1, 1, 1, 3'd0);
        access("R8 store ro", 3'd0, 2'd0, 1, 0, 0, 3'd5);
        access("R8 pushpop ro", 3'd1, 2'd1, 1, 0, 0, 3'd5);
    endtask

    task automatic t_bad_kind();
        for (int k = 5; k < 8; k++) begin
            access("R9 kind", 3'(k), 2'd0, 1, 0, 1, 3'd6);
        end
    endtask

    task automatic t_back_to_back();
        // R11 and R10: two valid cycles in a row, each verdict one edge late.
        @(negedge clk);
        acc_valid = 1'b1; acc_kind = 3'd0; acc_priv = 2'd0;
        pg_present = 1; pg_writable = 1; pg_dirty = 0;
        @(negedge clk);
        expect_out("R11 first", 1'b1, 3'd0);
        acc_kind = 3'd1; pg_writable = 0; pg_dirty = 1;
        @(negedge clk);
        expect_out("R11 second", 1'b0, 3'd2);
        acc_kind = 3'd2;
        @(negedge clk);
        expect_out("R11 third", 1'b1, 3'd0);
        // Reset with valid still high clears the verdict.
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R10 reset after pass", 1'b0, 3'd0);
        rst_n = 1'b1;
        acc_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_classify();
        t_absent();
        t_plain_on_shadow();
        t_shadow_traffic();
        t_priv_write();
        t_plain_pages();
        t_bad_kind();
        t_back_to_back();
        summary();
    end

    initial begin
        #1_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

endmodule